// File: doc/BRIEF.md
# Offset-adjusted compare timer pair

This block keeps a free-running 64-bit system count and serves two compare timers from it. The first timer, the physical one, looks at the raw count. The second timer, the virtual one, looks at the raw count minus a 64-bit offset. Only a separate privileged write port can change that offset. Each timer holds a 64-bit compare value and a small control word, and drives one level-sensitive interrupt line. Software sets a deadline either as an absolute compare value or as a signed 32-bit distance from the timer's own view of the count.

A simple synchronous register port gives reads and writes of the counts, the compare values, the down-count views and the control words. Read data is combinational from the address. The privileged port writes the offset through either of two aliased addresses. A write to the offset changes the virtual timer's status in the cycle that follows the write edge, and the virtual interrupt follows one clock later. The physical timer does not see the offset at all.

Register port map: 0x0 physical count (read-only), 0x1 virtual count (read-only), 0x2/0x3/0x4 physical compare / down-count / control, 0x5/0x6/0x7 virtual compare / down-count / control, 0x8 offset (read-only on this port). Control word: bit 0 enable, bit 1 mask, bit 2 status (read-only). Privileged port: address 0 and address 1 both map to the offset, and addresses 2 and 3 are unused.

Top module: `offset_cmp_timers`

## Requirements
- R1: The system count (read at 0x0) increases by exactly one on each clock edge where cnt_en is high. It holds its value while cnt_en is low.
- R2: Reading 0x1 returns the system count minus the offset, modulo 2^64.
- R3: Status (control bit 2) is 1 only when the timer is enabled (bit 0) and its view is greater than or equal to its compare value, unsigned 64-bit. The physical view is the raw count. The virtual view is the count minus the offset. Status reads 0 while the timer is disabled.
- R4: Reading a down-count address (0x3 or 0x6) returns the low 32 bits of (compare − view), zero-extended to 64 bits.
- R5: Writing a down-count address sets compare to view + sign-extended bus_wdata[31:0]. Bits 63:32 of the write data are ignored.
- R6: A privileged offset write changes the virtual status right after the write edge. The virtual interrupt follows on the next edge. The physical status and interrupt are unchanged.
- R7: After reset the offset, both compare values, both control words and both interrupt lines are zero.
- R8: A privileged write to address 0 or address 1 stores all 64 bits into the same offset, readable at 0x8. Privileged writes to addresses 2 and 3 are ignored, and the offset changes only on a privileged write.
- R9: Register-port writes to 0x0, 0x1 and 0x8 are ignored: the count and the offset keep their values.
- R10: irq_o[0] (physical) and irq_o[1] (virtual) each equal enable AND status AND NOT mask (control bit 1), registered one clock after the state that produces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | System count increments while high |
| bus_we | input | 1 | Register port write strobe |
| bus_addr | input | ADDR_W (4) | Register port address |
| bus_wdata | input | CNT_W (64) | Register port write data |
| bus_rdata | output | CNT_W (64) | Register port read data, combinational from bus_addr |
| priv_we | input | 1 | Privileged port write strobe |
| priv_addr | input | PRIV_ADDR_W (2) | Privileged port address (0 and 1 both select the offset) |
| priv_wdata | input | CNT_W (64) | Privileged port write data |
| irq_o | output | 2 | Interrupt lines, bit 0 physical, bit 1 virtual |

## Verification
On every cycle the assertions check the count stepping and holding with cnt_en, that the offset stays put unless the privileged strobe is high, that a disabled timer never reports status, and that a raised interrupt always comes from an enabled, unmasked timer one edge earlier. The bench scenarios cover the arithmetic and the ordering: modulo subtraction in the virtual count, sign extension of down-count writes, the exact compare boundary, the aliased and ignored offset addresses, and the one-cycle split between the status change and the interrupt change after an offset write.

// File: rtl/oct_pkg.sv
package oct_pkg;
   localparam int NUM_TIMERS    = 2;
   localparam int TIMER_PHYS    = 0;
   localparam int TIMER_VIRT    = 1;

   // register port map
   localparam int A_PCNT        = 0;
   localparam int A_VCNT        = 1;
   localparam int A_TBASE       = 2;
   localparam int A_TSTRIDE     = 3;
   localparam int A_OFF         = 8;
   localparam int A_CMP_OFS     = 0;
   localparam int A_DOWN_OFS    = 1;
   localparam int A_CTL_OFS     = 2;

   // privileged port map
   localparam int PA_OFF_MAIN   = 0;
   localparam int PA_OFF_ALIAS  = 1;

   // control word bits
   localparam int CTL_EN_BIT    = 0;
   localparam int CTL_MASK_BIT  = 1;
   localparam int CTL_STAT_BIT  = 2;

   typedef struct packed {
      logic mask;
      logic en;
   } tmr_ctl_t;
endpackage

// File: rtl/oct_counter.sv
module oct_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (inc_i)  cnt_o <= cnt_o + ONE;
   end
endmodule

// File: rtl/oct_offset_reg.sv
module oct_offset_reg
   import oct_pkg::*;
#(
   parameter int W    = 64,
   parameter int PA_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [PA_W-1:0] addr_i,
   input  logic [W-1:0]    wdata_i,
   output logic [W-1:0]    off_o
);
   logic hit;

   assign hit = we_i && ((addr_i == PA_W'(PA_OFF_MAIN)) ||
                         (addr_i == PA_W'(PA_OFF_ALIAS)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    off_o <= '0;
      else if (hit)  off_o <= wdata_i;
   end
endmodule

// File: rtl/oct_timer.sv
module oct_timer
   import oct_pkg::*;
#(
   parameter int CNT_W      = 64,
   parameter int DVIEW_W    = 32,
   parameter bit HAS_OFFSET = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [CNT_W-1:0]   off_i,
   input  logic               cmp_we,
   input  logic [CNT_W-1:0]   cmp_wdata,
   input  logic               down_we,
   input  logic [DVIEW_W-1:0] down_wdata,
   input  logic               ctl_we,
   input  tmr_ctl_t           ctl_wdata,
   output logic [CNT_W-1:0]   view_o,
   output logic [CNT_W-1:0]   cmp_o,
   output logic [DVIEW_W-1:0] down_o,
   output logic               en_o,
   output logic               mask_o,
   output logic               status_o,
   output logic               irq_o
);
   localparam int EXT_W = CNT_W - DVIEW_W;

   tmr_ctl_t         ctl_q;
   logic [CNT_W-1:0] down_sext;
   logic [CNT_W-1:0] diff;

   generate
      if (HAS_OFFSET) begin : g_offset
         assign view_o = cnt_i - off_i;
      end else begin : g_plain
         logic unused_off;
         assign unused_off = ^off_i;
         assign view_o     = cnt_i;
      end
   endgenerate

   assign down_sext = {{EXT_W{down_wdata[DVIEW_W-1]}}, down_wdata};
   assign diff      = cmp_o - view_o;
   assign down_o    = diff[DVIEW_W-1:0];
   assign en_o      = ctl_q.en;
   assign mask_o    = ctl_q.mask;
   assign status_o  = ctl_q.en && (view_o >= cmp_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_o <= '0;
      else if (down_we)  cmp_o <= view_o + down_sext;
      else if (cmp_we)   cmp_o <= cmp_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl_q <= '0;
      else if (ctl_we)  ctl_q <= ctl_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= ctl_q.en && status_o && !ctl_q.mask;
   end
endmodule

// File: rtl/offset_cmp_timers.sv
module offset_cmp_timers
   import oct_pkg::*;
#(
   parameter int CNT_W       = 64,
   parameter int DVIEW_W     = 32,
   parameter int ADDR_W      = 4,
   parameter int PRIV_ADDR_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cnt_en,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [CNT_W-1:0]       bus_wdata,
   output logic [CNT_W-1:0]       bus_rdata,
   input  logic                   priv_we,
   input  logic [PRIV_ADDR_W-1:0] priv_addr,
   input  logic [CNT_W-1:0]       priv_wdata,
   output logic [1:0]             irq_o
);
   localparam int NT       = NUM_TIMERS;
   localparam int TOP_ADDR = A_OFF;

   generate
      if (CNT_W <= DVIEW_W) begin : g_bad_width
         $error("CNT_W must exceed DVIEW_W");
      end
      if ((1 << ADDR_W) <= TOP_ADDR) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (PRIV_ADDR_W < 1) begin : g_bad_paddr
         $error("PRIV_ADDR_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]   cnt_w;
   logic [CNT_W-1:0]   off_w;
   logic [CNT_W-1:0]   view_w [NT];
   logic [CNT_W-1:0]   cmp_w  [NT];
   logic [DVIEW_W-1:0] down_w [NT];
   logic [NT-1:0]      en_v;
   logic [NT-1:0]      mask_v;
   logic [NT-1:0]      status_v;
   logic [NT-1:0]      irq_v;

   oct_counter #(.CNT_W(CNT_W)) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_en),
      .cnt_o (cnt_w)
   );

   oct_offset_reg #(.W(CNT_W), .PA_W(PRIV_ADDR_W)) i_offset (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (priv_we),
      .addr_i  (priv_addr),
      .wdata_i (priv_wdata),
      .off_o   (off_w)
   );

   generate
      for (genvar t = 0; t < NT; t++) begin : g_tmr
         localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(A_TBASE + A_TSTRIDE*t + A_CMP_OFS);
         localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(A_TBASE + A_TSTRIDE*t + A_DOWN_OFS);
         localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(A_TBASE + A_TSTRIDE*t + A_CTL_OFS);

         tmr_ctl_t ctl_wd;
         assign ctl_wd.en   = bus_wdata[CTL_EN_BIT];
         assign ctl_wd.mask = bus_wdata[CTL_MASK_BIT];

         oct_timer #(
            .CNT_W      (CNT_W),
            .DVIEW_W    (DVIEW_W),
            .HAS_OFFSET (t == TIMER_VIRT)
         ) i_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt_w),
            .off_i      (off_w),
            .cmp_we     (bus_we && (bus_addr == A_CMP)),
            .cmp_wdata  (bus_wdata),
            .down_we    (bus_we && (bus_addr == A_DOWN)),
            .down_wdata (bus_wdata[DVIEW_W-1:0]),
            .ctl_we     (bus_we && (bus_addr == A_CTL)),
            .ctl_wdata  (ctl_wd),
            .view_o     (view_w[t]),
            .cmp_o      (cmp_w[t]),
            .down_o     (down_w[t]),
            .en_o       (en_v[t]),
            .mask_o     (mask_v[t]),
            .status_o   (status_v[t]),
            .irq_o      (irq_v[t])
         );
      end
   endgenerate

   assign irq_o = irq_v;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_PCNT))      bus_rdata = cnt_w;
      else if (bus_addr == ADDR_W'(A_VCNT)) bus_rdata = view_w[TIMER_VIRT];
      else if (bus_addr == ADDR_W'(A_OFF))  bus_rdata = off_w;
      for (int t = 0; t < NT; t++) begin
         if (bus_addr == ADDR_W'(A_TBASE + A_TSTRIDE*t + A_CMP_OFS))
            bus_rdata = cmp_w[t];
         if (bus_addr == ADDR_W'(A_TBASE + A_TSTRIDE*t + A_DOWN_OFS))
            bus_rdata = CNT_W'(down_w[t]);
         if (bus_addr == ADDR_W'(A_TBASE + A_TSTRIDE*t + A_CTL_OFS))
            bus_rdata = CNT_W'({status_v[t], mask_v[t], en_v[t]});
      end
   end
endmodule

// File: rtl/oct_checker.sv
module oct_checker #(
   parameter int CNT_W = 64,
   parameter int NT    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             priv_we,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] offset,
   input logic [NT-1:0]    en,
   input logic [NT-1:0]    mask,
   input logic [NT-1:0]    status,
   input logic [NT-1:0]    irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> (cnt == $past(cnt) + ONE));

   p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt));

   p_off_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !priv_we |=> $stable(offset));

   generate
      for (genvar t = 0; t < NT; t++) begin : g_chk
         p_dis_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !en[t] |-> !status[t]);

         p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
            irq[t] |-> ($past(en[t]) && $past(status[t]) && !$past(mask[t])));
      end
   endgenerate
endmodule

bind offset_cmp_timers oct_checker #(.CNT_W(CNT_W), .NT(2)) i_oct_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_en  (cnt_en),
   .priv_we (priv_we),
   .cnt     (cnt_w),
   .offset  (off_w),
   .en      (en_v),
   .mask    (mask_v),
   .status  (status_v),
   .irq     (irq_o)
);

// File: tb/test_offset_cmp_timers.sv
`timescale 1ns/1ps
module test_offset_cmp_timers;
   localparam logic [3:0] A_PCNT = 4'h0, A_VCNT = 4'h1, A_PCMP = 4'h2, A_PDOWN = 4'h3,
                          A_PCTL = 4'h4, A_VCMP = 4'h5, A_VDOWN = 4'h6, A_VCTL = 4'h7,
                          A_OFF  = 4'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        priv_we = 1'b0;
   logic [1:0]  priv_addr = '0;
   logic [63:0] priv_wdata = '0;
   logic [1:0]  irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   offset_cmp_timers i_offset_cmp_timers (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .priv_we(priv_we), .priv_addr(priv_addr), .priv_wdata(priv_wdata),
      .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic chk_rd(input string req, input logic [3:0] a, input logic [63:0] exp);
      logic [63:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic pwr(input logic [1:0] a, input logic [63:0] d);
      priv_we = 1'b1; priv_addr = a; priv_wdata = d;
      tick();
      priv_we = 1'b0;
   endtask

   task automatic t_reset();
      chk_rd("R7 count", A_PCNT, 64'd0);
      chk_rd("R7 offset", A_OFF, 64'd0);
      chk_rd("R7 pcmp", A_PCMP, 64'd0);
      chk_rd("R7 vcmp", A_VCMP, 64'd0);
      chk_rd("R7 pctl", A_PCTL, 64'd0);
      chk_rd("R7 vctl", A_VCTL, 64'd0);
      chk("R7 irq", {62'd0, irq_o}, 64'd0);
   endtask

   task automatic t_counter();
      cnt_en = 1'b1;
      repeat (100) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
      chk_rd("R1 count after 100", A_PCNT, 64'd100);
      repeat (5) tick();
      chk_rd("R1 count holds", A_PCNT, 64'd100);
   endtask

   task automatic t_virt_count();
      pwr(2'd0, 64'd30);
      chk_rd("R2 virtual count", A_VCNT, 64'd70);
      chk_rd("R8 main address", A_OFF, 64'd30);
      pwr(2'd1, 64'd250);
      chk_rd("R8 alias address", A_OFF, 64'd250);
      chk_rd("R2 modulo wrap", A_VCNT, 64'hFFFF_FFFF_FFFF_FF6A);
      pwr(2'd2, 64'd7);
      chk_rd("R8 unused priv addr ignored", A_OFF, 64'd250);
      wr(A_OFF, 64'd5);
      chk_rd("R9 offset write ignored", A_OFF, 64'd250);
      wr(A_PCNT, 64'd999);
      chk_rd("R9 count write ignored", A_PCNT, 64'd100);
      wr(A_VCNT, 64'd999);
      chk_rd("R9 vcount write ignored", A_PCNT, 64'd100);
   endtask

   task automatic t_status();
      pwr(2'd0, 64'd40);
      wr(A_VCMP, 64'd60);
      wr(A_VCTL, 64'd1);
      chk_rd("R3 virt equal boundary", A_VCTL, 64'd5);
      tick();
      chk("R10 virt irq", {63'd0, irq_o[1]}, 64'd1);
      wr(A_VCMP, 64'd61);
      chk_rd("R3 virt below cmp", A_VCTL, 64'd1);
      tick();
      chk("R10 virt irq drops", {63'd0, irq_o[1]}, 64'd0);
      wr(A_PCMP, 64'd100);
      wr(A_PCTL, 64'd1);
      chk_rd("R3 phys equal boundary", A_PCTL, 64'd5);
      tick();
      chk("R10 phys irq", {63'd0, irq_o[0]}, 64'd1);
      wr(A_PCTL, 64'd3);
      chk_rd("R10 masked ctl", A_PCTL, 64'd7);
      tick();
      chk("R10 masked irq low", {63'd0, irq_o[0]}, 64'd0);
      wr(A_PCMP, 64'd101);
      wr(A_PCTL, 64'd1);
      chk_rd("R3 phys below cmp", A_PCTL, 64'd1);
      wr(A_PCMP, 64'd50);
      wr(A_PCTL, 64'd0);
      chk_rd("R3 disabled status zero", A_PCTL, 64'd0);
      wr(A_PCTL, 64'd1);
      tick();
      chk("R10 phys irq on", {63'd0, irq_o[0]}, 64'd1);
   endtask

   task automatic t_reeval();
      pwr(2'd1, 64'd39);
      chk_rd("R6 status right after offset write", A_VCTL, 64'd5);
      chk("R6 virt irq one edge later", {63'd0, irq_o[1]}, 64'd0);
      tick();
      chk("R6 virt irq raised", {63'd0, irq_o[1]}, 64'd1);
      chk("R6 phys irq unaffected", {63'd0, irq_o[0]}, 64'd1);
      chk_rd("R6 phys status unaffected", A_PCTL, 64'd5);
   endtask

   task automatic t_down();
      chk_rd("R4 down zero", A_VDOWN, 64'd0);
      wr(A_VDOWN, 64'hABCD_0123_FFFF_FFF6);
      chk_rd("R5 negative down write", A_VCMP, 64'd51);
      chk_rd("R4 negative down read", A_VDOWN, 64'h0000_0000_FFFF_FFF6);
      wr(A_PDOWN, 64'd20);
      chk_rd("R5 phys down write", A_PCMP, 64'd120);
      chk_rd("R4 phys down read", A_PDOWN, 64'd20);
      wr(A_VDOWN, 64'h0000_0000_7FFF_FFFF);
      chk_rd("R5 max positive down write", A_VCMP, 64'h0000_0000_8000_003C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counter();
      t_virt_count();
      t_status();
      t_reeval();
      t_down();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule